// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Window

This block gives a host a read-only view of up to four serial flash devices through one linear address window. A host read presents a byte offset into the window; the block splits that offset into a device number and a per-device byte address. It then runs one single-bit SPI read transaction on that device's select line and returns a 32-bit word. The host side is a level request with a wait signal. The host holds the request and address until it sees the wait signal low at a clock edge, and the response word is valid in that same cycle.

Every device owns a fixed slice of the window: 16 MiB with the default parameters, so the default window spans 64 MiB. Software programs how much of the window is populated, and how much of each slice is backed by a device, in units of 512 KiB. Reads that fall outside either limit complete at once with all ones and never touch the SPI pins. A hold input lets a software-driven transfer engine take the SPI bus: while it is high, no new host read starts. The serial clock runs at the bus clock rate. The block drives a per-cycle enable for the serial clock, and the pad logic gates the bus clock with it, so each enabled bus cycle carries one bit.

Top module: `flash_rd_window`

## Requirements
- R1: The device index is the window offset divided by the slice size (offset bits above SLICE_AW). The remainder, zero-extended to 24 bits, is sent as the flash address. Only the selected device's active-low select `spi_cs_n[index]` goes low.
- R2: An accepted read uses exactly 64 consecutive cycles with `spi_sck_gate` high. The first 8 bits on `spi_mosi` are opcode 0x03, MSB first. The next 24 bits are the flash address, MSB first. In the final 32 cycles `spi_mosi` is 0 and `spi_miso` is sampled, one bit per clock.
- R3: The first byte received lands in `rsp_data[7:0]`, the second in `[15:8]`, the third in `[23:16]` and the fourth in `[31:24]`. Each byte arrives MSB first.
- R4: A read is outside the map when offset / 2^UNIT_AW >= `cfg_total_units`, or when (offset mod slice size) / 2^UNIT_AW >= `cfg_dev_units`. Such a read returns 0xFFFFFFFF, and no select line is asserted for it.
- R5: `hwait` equals `req_valid` in every cycle except the response cycle. In the response cycle `hwait` is 0, `rsp_valid` is 1 for that single cycle, and `rsp_data` holds the result. An unstalled in-map read sees 65 wait cycles; an outside-the-map read sees 1.
- R6: While `host_hold` is 1, no new read begins: the request waits with `hwait` high and all selects high, whether or not its address is in the map. The read starts once `host_hold` returns to 0. A transaction already under way runs to completion.
- R7: At most one select is low at any time. `spi_sck_gate` is high only while a select is low.
- R8: During and just after reset, all selects are high, `spi_sck_gate` and `rsp_valid` are 0, and `hwait` is 0 while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also the serial clock source |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_hold | input | 1 | Stall bit from the host-side configuration byte; holds off new reads |
| cfg_total_units | input | UNITS_W | Populated window size in 2^UNIT_AW-byte units |
| cfg_dev_units | input | UNITS_W | Backed size of each slice in 2^UNIT_AW-byte units |
| req_valid | input | 1 | Host read request, held until the response cycle |
| req_addr | input | WIN_AW | Byte offset into the window |
| hwait | output | 1 | Host wait; high while the request is not yet answered |
| rsp_valid | output | 1 | Response cycle marker |
| rsp_data | output | 32 | Read word, little-endian byte order |
| spi_cs_n | output | NUM_CS | Active-low device selects |
| spi_sck_gate | output | 1 | Serial clock enable, one bit per bus cycle |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with NUM_CS=4, SLICE_AW=8 and UNIT_AW=4. This gives a 1 KiB window of four 256-byte slices in 16-byte units, so the range limits cut at addresses the bench can reach. The fully populated map is swept over every one of the 1024 offsets. A partial map (40 total units, 10 per device) is swept over every third offset. Explicit reads sit just below and just above each limit, and the empty map is tried as well. Holding the bus before a read and during a read shows the stall and completion behaviour, with latency counted in cycles.

// File: rtl/flash_win_pkg.sv
package flash_win_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RESP = 2'd2
  } win_state_t;

  // Index of the allocation unit that contains a byte offset.
  function automatic logic [31:0] unit_of(input logic [31:0] byte_off, input int unit_aw);
    return byte_off >> unit_aw;
  endfunction

  // True when the unit holding byte_off is below a programmed unit count.
  function automatic logic below_units(input logic [31:0] byte_off,
                                       input logic [31:0] units,
                                       input int unit_aw);
    return unit_of(byte_off, unit_aw) < units;
  endfunction

endpackage

// File: rtl/win_decode.sv
module win_decode
  import flash_win_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int SLICE_AW  = 24,
  parameter int UNIT_AW   = 19,
  parameter int ADDR_BITS = 24,
  localparam int CS_W     = $clog2(NUM_CS),
  localparam int WIN_AW   = SLICE_AW + CS_W,
  localparam int UNITS_W  = WIN_AW - UNIT_AW + 1
) (
  input  logic [WIN_AW-1:0]    addr,
  input  logic [UNITS_W-1:0]   total_units,
  input  logic [UNITS_W-1:0]   dev_units,
  output logic [CS_W-1:0]      cs_idx,
  output logic [ADDR_BITS-1:0] faddr,
  output logic                 in_range
);

  logic [SLICE_AW-1:0] slice_off;
  logic                total_ok;
  logic                dev_ok;

  assign cs_idx    = addr[WIN_AW-1 -: CS_W];
  assign slice_off = addr[SLICE_AW-1:0];
  assign faddr     = ADDR_BITS'(slice_off);

  assign total_ok  = below_units(32'(addr), 32'(total_units), UNIT_AW);
  assign dev_ok    = below_units(32'(slice_off), 32'(dev_units), UNIT_AW);
  assign in_range  = total_ok && dev_ok;

endmodule

// File: rtl/spi_read_seq.sv
module spi_read_seq #(
  parameter int         ADDR_BITS = 24,
  parameter int         WORD_BITS = 32,
  parameter logic [7:0] RD_OPCODE = 8'h03,
  localparam int OUT_BITS   = 8 + ADDR_BITS,
  localparam int TOTAL_BITS = OUT_BITS + WORD_BITS,
  localparam int CNT_W      = $clog2(TOTAL_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_BITS-1:0] faddr,
  input  logic                 miso,
  output logic                 gate,
  output logic                 mosi,
  output logic                 last_bit,
  output logic [WORD_BITS-1:0] rx_word
);

  localparam int NBYTES = WORD_BITS / 8;

  logic                 busy;
  logic [CNT_W-1:0]     bit_cnt;
  logic [OUT_BITS-1:0]  tx_sr;
  logic [WORD_BITS-1:0] rx_sr;
  logic                 in_data;

  assign in_data  = (bit_cnt >= CNT_W'(OUT_BITS));
  assign last_bit = busy && (bit_cnt == CNT_W'(TOTAL_BITS - 1));
  assign gate     = busy;
  assign mosi     = busy && !in_data && tx_sr[OUT_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_cnt <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      bit_cnt <= '0;
      tx_sr   <= {RD_OPCODE, faddr};
    end else if (busy) begin
      bit_cnt <= bit_cnt + 1'b1;
      tx_sr   <= {tx_sr[OUT_BITS-2:0], 1'b0};
      if (in_data) rx_sr <= {rx_sr[WORD_BITS-2:0], miso};
      if (last_bit) busy <= 1'b0;
    end
  end

  // First byte shifted in ends up in the top of rx_sr; place it lowest.
  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign rx_word[8*b +: 8] = rx_sr[WORD_BITS-8-8*b +: 8];
  end

endmodule

// File: rtl/cs_select.sv
module cs_select #(
  parameter int NUM_CS = 4,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drop,
  input  logic [CS_W-1:0]   idx,
  output logic [NUM_CS-1:0] cs_n
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cs_n[g] <= 1'b1;
      else if (load) cs_n[g] <= (idx != CS_W'(g));
      else if (drop) cs_n[g] <= 1'b1;
    end
  end

endmodule

// File: rtl/flash_rd_window.sv
module flash_rd_window
  import flash_win_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int SLICE_AW = 24,
  parameter int UNIT_AW  = 19,
  localparam int CS_W    = $clog2(NUM_CS),
  localparam int WIN_AW  = SLICE_AW + CS_W,
  localparam int UNITS_W = WIN_AW - UNIT_AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_hold,
  input  logic [UNITS_W-1:0] cfg_total_units,
  input  logic [UNITS_W-1:0] cfg_dev_units,
  input  logic               req_valid,
  input  logic [WIN_AW-1:0]  req_addr,
  output logic               hwait,
  output logic               rsp_valid,
  output logic [31:0]        rsp_data,
  output logic [NUM_CS-1:0]  spi_cs_n,
  output logic               spi_sck_gate,
  output logic               spi_mosi,
  input  logic               spi_miso
);

  localparam int ADDR_BITS = 24;
  localparam int WORD_BITS = 32;

  win_state_t           state;
  logic [CS_W-1:0]      dec_cs;
  logic [ADDR_BITS-1:0] dec_faddr;
  logic                 dec_in_range;
  logic                 oor_q;
  logic [WORD_BITS-1:0] rx_word;

  // Named events used by the checker.
  logic can_accept;
  logic start_xfer;
  logic oor_accept;
  logic xfer_active;
  logic last_bit;

  win_decode #(
    .NUM_CS(NUM_CS), .SLICE_AW(SLICE_AW), .UNIT_AW(UNIT_AW), .ADDR_BITS(ADDR_BITS)
  ) dec_i (
    .addr(req_addr), .total_units(cfg_total_units), .dev_units(cfg_dev_units),
    .cs_idx(dec_cs), .faddr(dec_faddr), .in_range(dec_in_range)
  );

  assign can_accept  = (state == ST_IDLE) && req_valid && !host_hold;
  assign start_xfer  = can_accept && dec_in_range;
  assign oor_accept  = can_accept && !dec_in_range;
  assign xfer_active = (state == ST_XFER);

  spi_read_seq #(
    .ADDR_BITS(ADDR_BITS), .WORD_BITS(WORD_BITS), .RD_OPCODE(8'h03)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start_xfer), .faddr(dec_faddr),
    .miso(spi_miso), .gate(spi_sck_gate), .mosi(spi_mosi),
    .last_bit(last_bit), .rx_word(rx_word)
  );

  cs_select #(.NUM_CS(NUM_CS)) sel_i (
    .clk(clk), .rst_n(rst_n), .load(start_xfer), .drop(last_bit),
    .idx(dec_cs), .cs_n(spi_cs_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      oor_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_xfer) begin
            state <= ST_XFER;
            oor_q <= 1'b0;
          end else if (oor_accept) begin
            state <= ST_RESP;
            oor_q <= 1'b1;
          end
        end
        ST_XFER: if (last_bit) state <= ST_RESP;
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = (state == ST_RESP);
  assign hwait     = req_valid && !rsp_valid;
  assign rsp_data  = !rsp_valid ? '0 : (oor_q ? '1 : rx_word);

endmodule

// File: rtl/flash_rd_window_chk.sv
module flash_rd_window_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              hwait,
  input logic              rsp_valid,
  input logic [31:0]       rsp_data,
  input logic [NUM_CS-1:0] spi_cs_n,
  input logic              spi_sck_gate,
  input logic              stall,
  input logic              xfer_active,
  input logic              oor_accept,
  input logic              last_bit
);

  logic [6:0] gate_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            gate_cnt <= '0;
    else if (spi_sck_gate) gate_cnt <= gate_cnt + 1'b1;
    else                   gate_cnt <= '0;
  end

  // R7
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  // R7
  clock_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck_gate |-> (~spi_cs_n != '0));

  // R2
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |-> (gate_cnt == 7'd63));

  // R4
  oor_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oor_accept |=> (rsp_valid && rsp_data == 32'hFFFF_FFFF && (&spi_cs_n)));

  // R5
  resp_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !hwait);

  // R5
  resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  busy_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && req_valid) |-> hwait);

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !xfer_active) |=> !xfer_active);

  // R6
  xfer_runs_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && !last_bit) |=> xfer_active);

endmodule

bind flash_rd_window flash_rd_window_chk #(.NUM_CS(NUM_CS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hwait(hwait),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .spi_cs_n(spi_cs_n),
  .spi_sck_gate(spi_sck_gate), .stall(host_hold), .xfer_active(xfer_active),
  .oor_accept(oor_accept), .last_bit(last_bit)
);

// File: tb/flash_rd_window_tb_top.sv
`timescale 1ns/1ps
module flash_rd_window_tb_top;

  localparam int NUM_CS   = 4;
  localparam int SLICE_AW = 8;
  localparam int UNIT_AW  = 4;
  localparam int WIN_AW   = 10;
  localparam int UNITS_W  = 7;
  localparam int SLICE_SZ = 256;
  localparam int UNIT_SZ  = 16;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               host_hold = 1'b0;
  logic [UNITS_W-1:0] cfg_total_units = '0;
  logic [UNITS_W-1:0] cfg_dev_units = '0;
  logic               req_valid = 1'b0;
  logic [WIN_AW-1:0]  req_addr = '0;
  logic               hwait;
  logic               rsp_valid;
  logic [31:0]        rsp_data;
  logic [NUM_CS-1:0]  spi_cs_n;
  logic               spi_sck_gate;
  logic               spi_mosi;
  logic               spi_miso = 1'b0;

  always #4 clk = ~clk;

  flash_rd_window #(.NUM_CS(NUM_CS), .SLICE_AW(SLICE_AW), .UNIT_AW(UNIT_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_hold(host_hold),
    .cfg_total_units(cfg_total_units), .cfg_dev_units(cfg_dev_units),
    .req_valid(req_valid), .req_addr(req_addr), .hwait(hwait),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .spi_cs_n(spi_cs_n),
    .spi_sck_gate(spi_sck_gate), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Flash content model: one byte per (device, address).
  function automatic logic [7:0] fbyte(input int cs, input logic [23:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd13;
    return m ^ a[15:8] ^ a[23:16] ^ 8'(cs * 71) ^ 8'h5a;
  endfunction

  function automatic logic [31:0] exp_word(input int cs, input int off);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = fbyte(cs, 24'(off + i));
    return w;
  endfunction

  function automatic bit in_map(input int addr, input int total, input int dev);
    return ((addr / UNIT_SZ) < total) && (((addr % SLICE_SZ) / UNIT_SZ) < dev);
  endfunction

  function automatic int low_index(input logic [NUM_CS-1:0] v);
    for (int i = 0; i < NUM_CS; i++) if (!v[i]) return i;
    return -1;
  endfunction

  // Serial flash model and pin monitors.
  int          fcnt = 0;
  logic [31:0] fsr = '0;
  int          sck_cycles = 0;
  int          mosi_bad = 0;
  int          sel_events = 0;
  int          last_sel = -1;
  int          multi_sel = 0;
  logic [NUM_CS-1:0] prev_cs = '1;

  always @(posedge clk) begin
    if (&spi_cs_n) fcnt <= 0;
    else if (spi_sck_gate) begin
      if (fcnt < 32) fsr <= {fsr[30:0], spi_mosi};
      else if (spi_mosi) mosi_bad <= mosi_bad + 1;
      fcnt <= fcnt + 1;
    end
    if (spi_sck_gate) sck_cycles <= sck_cycles + 1;
  end

  always @(negedge clk) begin
    if (fcnt >= 32 && fcnt < 64 && !(&spi_cs_n)) begin
      logic [7:0] b;
      b = fbyte(low_index(spi_cs_n), fsr[23:0] + 24'((fcnt - 32) / 8));
      spi_miso = b[7 - ((fcnt - 32) % 8)];
    end else begin
      spi_miso = 1'b0;
    end
    if ($countones(~spi_cs_n) > 1) multi_sel++;
    if ((&prev_cs) && !(&spi_cs_n)) begin
      sel_events++;
      last_sel = low_index(spi_cs_n);
    end
    prev_cs = spi_cs_n;
  end

  task automatic clear_mon();
    sck_cycles = 0;
    mosi_bad   = 0;
    sel_events = 0;
    last_sel   = -1;
    multi_sel  = 0;
  endtask

  task automatic set_map(input int total, input int dev);
    @(negedge clk);
    cfg_total_units = UNITS_W'(total);
    cfg_dev_units   = UNITS_W'(dev);
  endtask

  task automatic post_checks(input int addr, input bit inr);
    int cs;
    int off;
    cs  = addr / SLICE_SZ;
    off = addr % SLICE_SZ;
    chk(sel_events == (inr ? 1 : 0), inr ? "R1" : "R4", "select events",
        64'(sel_events), 64'(inr ? 1 : 0));
    chk(multi_sel == 0, "R7", "multiple selects", 64'(multi_sel), 64'd0);
    if (inr) begin
      chk(last_sel == cs, "R1", "device index", 64'(last_sel), 64'(cs));
      chk(fsr[31:24] == 8'h03, "R2", "opcode", 64'(fsr[31:24]), 64'h03);
      chk(fsr[23:0] == 24'(off), "R1", "flash address", 64'(fsr[23:0]), 64'(off));
      chk(sck_cycles == 64, "R2", "clock cycles", 64'(sck_cycles), 64'd64);
      chk(mosi_bad == 0, "R2", "mosi in data phase", 64'(mosi_bad), 64'd0);
    end else begin
      chk(sck_cycles == 0, "R4", "clock cycles", 64'(sck_cycles), 64'd0);
    end
  endtask

  task automatic do_read(input int addr, input int total, input int dev);
    bit inr;
    int waits;
    logic [31:0] exp;
    inr = in_map(addr, total, dev);
    exp = inr ? exp_word(addr / SLICE_SZ, addr % SLICE_SZ) : 32'hFFFF_FFFF;
    @(negedge clk);
    clear_mon();
    req_valid = 1'b1;
    req_addr  = WIN_AW'(addr);
    #1;
    waits = 0;
    while (hwait && waits < 1000) begin
      waits++;
      @(negedge clk);
      #1;
    end
    chk(rsp_valid, "R5", "response valid", 64'(rsp_valid), 64'd1);
    chk(rsp_data == exp, inr ? "R3" : "R4", $sformatf("data @%0d", addr),
        64'(rsp_data), 64'(exp));
    chk(waits == (inr ? 65 : 1), "R5", "wait cycles", 64'(waits), 64'(inr ? 65 : 1));
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(!rsp_valid && !hwait, "R5", "idle after response",
        64'({rsp_valid, hwait}), 64'd0);
    post_checks(addr, inr);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    int waits;
    logic [31:0] exp;

    // R8: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(&spi_cs_n, "R8", "selects in reset", 64'(spi_cs_n), 64'hF);
    chk(!spi_sck_gate && !rsp_valid && !hwait, "R8", "outputs in reset",
        64'({spi_sck_gate, rsp_valid, hwait}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk((&spi_cs_n) && !spi_sck_gate && !rsp_valid && !hwait, "R8", "after reset",
        64'({spi_cs_n, spi_sck_gate, rsp_valid, hwait}), 64'h78);

    // Full map, every offset (R1 R2 R3 R5)
    set_map(64, 16);
    for (int a = 0; a < 1024; a++) do_read(a, 64, 16);

    // Partial map, every third offset (R4)
    set_map(40, 10);
    for (int a = 0; a < 1024; a += 3) do_read(a, 40, 10);

    // Boundaries of the total limit (R4)
    set_map(40, 16);
    do_read(639, 40, 16);
    do_read(640, 40, 16);
    // Boundaries of the per-device limit (R4)
    set_map(64, 10);
    do_read(159, 64, 10);
    do_read(160, 64, 10);
    do_read(415, 64, 10);
    do_read(416, 64, 10);
    // Empty maps (R4)
    set_map(0, 16);
    do_read(0, 0, 16);
    do_read(1023, 0, 16);
    set_map(64, 0);
    do_read(300, 64, 0);

    // R6: hold before the request, in-map address
    set_map(64, 16);
    @(negedge clk);
    clear_mon();
    host_hold = 1'b1;
    req_valid = 1'b1;
    req_addr  = WIN_AW'(517);
    repeat (20) @(negedge clk);
    #1;
    chk(hwait && (&spi_cs_n) && sck_cycles == 0, "R6", "held read",
        64'({hwait, spi_cs_n}), 64'h1F);
    host_hold = 1'b0;
    waits = 0;
    while (hwait && waits < 1000) begin
      waits++;
      @(negedge clk);
      #1;
    end
    exp = exp_word(2, 5);
    chk(rsp_valid && rsp_data == exp, "R6", "data after hold", 64'(rsp_data), 64'(exp));
    @(negedge clk);
    req_valid = 1'b0;
    post_checks(517, 1'b1);

    // R6: hold also stops an out-of-map read from answering
    set_map(8, 16);
    @(negedge clk);
    host_hold = 1'b1;
    req_valid = 1'b1;
    req_addr  = WIN_AW'(700);
    repeat (6) @(negedge clk);
    #1;
    chk(hwait && !rsp_valid, "R6", "held out-of-map", 64'({hwait, rsp_valid}), 64'h2);
    host_hold = 1'b0;
    @(negedge clk);
    #1;
    chk(rsp_valid && rsp_data == 32'hFFFF_FFFF, "R6", "out-of-map after hold",
        64'(rsp_data), 64'hFFFF_FFFF);
    @(negedge clk);
    req_valid = 1'b0;

    // R6: hold raised during a transfer does not abort it
    set_map(64, 16);
    @(negedge clk);
    clear_mon();
    req_valid = 1'b1;
    req_addr  = WIN_AW'(842);
    #1;
    waits = 0;
    while (hwait && waits < 1000) begin
      waits++;
      if (waits == 10) host_hold = 1'b1;
      @(negedge clk);
      #1;
    end
    exp = exp_word(3, 74);
    chk(rsp_data == exp, "R6", "data with late hold", 64'(rsp_data), 64'(exp));
    chk(waits == 65, "R6", "late hold latency", 64'(waits), 64'd65);
    @(negedge clk);
    req_valid = 1'b0;
    host_hold = 1'b0;
    post_checks(842, 1'b1);

    done_flag = 1'b1;
    report();
  end

endmodule